// File: doc/BRIEF.md
# Free-Running Power-Management Tick Timer

This block keeps a free-running count of a fixed-rate timing enable. In the system that enable pulses at about 3.579545 MHz; here it is a one-cycle `tick_en` input, so the block runs on any fast core clock. Software reads the count through a simple register port. The port's register window holds two registers: a control word and a 32-bit read-only count.

The control word holds three bits. One bit picks the counter width: 24 bits (the default) or 32 bits. One bit freezes the count. One bit forces the count to zero and holds it there. A read of the count register catches the value on the read strobe edge and holds that snapshot on `bus_rdata`, so a read never mixes bits from two different count values. The narrow and wide widths are parameters. A small instance can therefore run through both wrap points in a short bench.

Top module: `pmtmr_top`

## Requirements
- R1: After reset the count and the control word are zero, and `bus_rdata` is zero.
- R2: On each clock edge where `tick_en` is high and neither freeze nor clear is set, the count rises by exactly one. Without `tick_en` it does not change.
- R3: When control bit 11 is 0 (narrow mode), the count wraps from all-ones in NARROW_W bits (0xFFFFFF by default) to zero. Bits above NARROW_W read as zero.
- R4: When control bit 11 is 1 (wide mode), the count uses WIDE_W bits (32 by default) and wraps from all-ones to zero.
- R5: While control bit 6 is 1, ticks are ignored and the count holds its value.
- R6: While control bit 14 is 1, the count is zero and stays zero, whatever the ticks and bit 6 do.
- R7: When the mode changes from wide to narrow, the bits of the count above NARROW_W are cleared on the next edge. The low bits keep their value.
- R8: A read strobe at offset 0x08 loads `bus_rdata` on that edge with the count as it stood at the strobe. `bus_rdata` then holds until the next read strobe.
- R9: The control word is written and read at offset 0x00. Only bits 14, 11 and 6 are stored; all other bits read as zero. A write to offset 0x08 leaves the count unchanged. A read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle timing enable that advances the count |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (8) | Byte offset in the register window |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, loaded on the read strobe edge and held |

## Verification
A control write takes effect in the control register on its strobe edge. The counter acts on the new setting from the following edge. The bench therefore applies ticks only in the cycles after a write has finished. Each tick advances the count on the edge where `tick_en` is high. Read data shows up on `bus_rdata` one edge after the strobe. The bench drives every input on the falling edge and samples `bus_rdata` on the falling edge that follows the strobe edge. That timing is exactly one register stage, and the checks read nothing earlier. A second, narrow-width instance shares the same stimulus, so both wrap points (R3 and R4) are reached within a few thousand ticks.

// File: rtl/pmtmr_pkg.sv
package pmtmr_pkg;
   // control word bit positions, decoded by software
   localparam int FREEZE_BIT = 6;
   localparam int WIDE_BIT   = 11;
   localparam int CLEAR_BIT  = 14;
   // register window offsets
   localparam int CTRL_OFS   = 'h00;
   localparam int COUNT_OFS  = 'h08;

   typedef struct packed {
      logic clear;
      logic wide;
      logic freeze;
   } ctrl_t;
endpackage

// File: rtl/pmtmr_ctrl.sv
module pmtmr_ctrl
   import pmtmr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output ctrl_t             ctrl
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

   generate
      if (DATA_W <= CLEAR_BIT) begin : g_bad_width
         $error("pmtmr_ctrl: DATA_W too narrow for control bits");
      end
   endgenerate

   ctrl_t ctrl_q;
   logic  unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr && addr == CTRL_A) begin
         ctrl_q.clear  <= wdata[CLEAR_BIT];
         ctrl_q.wide   <= wdata[WIDE_BIT];
         ctrl_q.freeze <= wdata[FREEZE_BIT];
      end
   end

   assign ctrl = ctrl_q;

   // R9: writes outside the control offset leave the control word alone
   assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && addr == CTRL_A) |=> $stable(ctrl_q));
endmodule

// File: rtl/pmtmr_counter.sv
module pmtmr_counter
   import pmtmr_pkg::*;
#(
   parameter int NARROW_W = 24,
   parameter int WIDE_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  ctrl_t             ctrl,
   output logic [WIDE_W-1:0] count
);
   localparam logic [WIDE_W-1:0] ONE = WIDE_W'(1);

   generate
      if (NARROW_W < 1 || NARROW_W > WIDE_W) begin : g_bad_width
         $error("pmtmr_counter: need 1 <= NARROW_W <= WIDE_W");
      end
   endgenerate

   logic [WIDE_W-1:0] cnt_q, stepped, limited;

   assign stepped = (tick && !ctrl.freeze) ? cnt_q + ONE : cnt_q;

   generate
      if (WIDE_W > NARROW_W) begin : g_two_widths
         assign limited = ctrl.wide ? stepped
                        : {{(WIDE_W-NARROW_W){1'b0}}, stepped[NARROW_W-1:0]};

         // R3 / R7: narrow mode keeps the upper bits at zero from the next edge
         assert_narrow_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl.wide |=> cnt_q[WIDE_W-1:NARROW_W] == '0);
      end else begin : g_one_width
         assign limited = stepped;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (ctrl.clear) cnt_q <= '0;
      else                 cnt_q <= limited;
   end

   assign count = cnt_q;

   // R6: clear forces and holds zero
   assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.clear |=> cnt_q == '0);
   // R5: freeze holds the count
   assert_freeze_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.freeze && !ctrl.clear && ctrl.wide |=> $stable(cnt_q));
   // R2 / R4: one step per tick in wide mode
   assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !ctrl.freeze && !ctrl.clear && ctrl.wide |=> cnt_q == $past(cnt_q) + ONE);
   // R2: no tick, no change
   assert_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !ctrl.clear && ctrl.wide |=> $stable(cnt_q));
endmodule

// File: rtl/pmtmr_rdport.sv
module pmtmr_rdport
   import pmtmr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int WIDE_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDE_W-1:0] count,
   input  ctrl_t             ctrl,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] COUNT_A = ADDR_W'(COUNT_OFS);

   generate
      if (WIDE_W > DATA_W) begin : g_bad_width
         $error("pmtmr_rdport: WIDE_W exceeds DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] ctrl_word, rdata_q;

   always_comb begin
      ctrl_word             = '0;
      ctrl_word[CLEAR_BIT]  = ctrl.clear;
      ctrl_word[WIDE_BIT]   = ctrl.wide;
      ctrl_word[FREEZE_BIT] = ctrl.freeze;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd) begin
         if (addr == COUNT_A)     rdata_q <= DATA_W'(count);
         else if (addr == CTRL_A) rdata_q <= ctrl_word;
         else                     rdata_q <= '0;
      end
   end

   assign rdata = rdata_q;

   // R8: snapshot equals the count at the strobe edge
   assert_snapshot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd && addr == COUNT_A |=> rdata_q == DATA_W'($past(count)));
   // R8: read data holds between strobes
   assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(rdata_q));
endmodule

// File: rtl/pmtmr_top.sv
module pmtmr_top
   import pmtmr_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int NARROW_W = 24,
   parameter int WIDE_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);
   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("pmtmr_top: ADDR_W must reach offset 0x08");
      end
   endgenerate

   ctrl_t             ctrl;
   logic [WIDE_W-1:0] count;

   pmtmr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .ctrl(ctrl));

   pmtmr_counter #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .ctrl(ctrl), .count(count));

   pmtmr_rdport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIDE_W(WIDE_W)) u_rdport (
      .clk(clk), .rst_n(rst_n), .rd(bus_rd), .addr(bus_addr),
      .count(count), .ctrl(ctrl), .rdata(bus_rdata));
endmodule

// File: tb/pmtmr_top_tb_top.sv
`timescale 1ns/1ps
module pmtmr_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata_big, rdata_small;
   int          n_checks = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   pmtmr_top dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(rdata_big));

   pmtmr_top #(.NARROW_W(8), .WIDE_W(12)) dut_small (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(rdata_small));

   typedef struct packed {
      logic [15:0] ctrl;
      int          ticks;
      logic [31:0] exp_big;
      logic [31:0] exp_small;
   } vec_t;

   // control value, ticks, expected count (default instance, 8/12-bit instance)
   localparam vec_t VECS [10] = '{
      '{16'h0000,   10, 32'd10,   32'd10},   // R2 narrow counting
      '{16'h0000,  250, 32'd260,  32'd4},    // R3 narrow wrap (small)
      '{16'h0800,  300, 32'd560,  32'd304},  // R4 wide counting
      '{16'h0840,   50, 32'd560,  32'd304},  // R5 freeze
      '{16'h4800,   20, 32'd0,    32'd0},    // R6 clear and hold
      '{16'h0800, 4095, 32'd4095, 32'd4095}, // R4 up to wide all-ones (small)
      '{16'h0800,    1, 32'd4096, 32'd0},    // R4 wide wrap (small)
      '{16'h0800,  300, 32'd4396, 32'd300},  // R2 wide counting
      '{16'h0000,    0, 32'd4396, 32'd44},   // R7 narrowing clears upper bits
      '{16'h0800,    0, 32'd4396, 32'd44}    // R7 upper bits stay cleared
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick_en = 1'b1;
      end
      @(negedge clk);
      tick_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1 rdata", rdata_big, 32'd0);
      bus_read(8'h08);
      check("R1 count", rdata_big, 32'd0);
      check("R1 count small", rdata_small, 32'd0);
      bus_read(8'h00);
      check("R1 ctrl", rdata_big, 32'd0);

      for (int v = 0; v < 10; v++) begin
         bus_write(8'h00, {16'h0, VECS[v].ctrl});
         ticks(VECS[v].ticks);
         bus_read(8'h08);
         check($sformatf("vector %0d big", v), rdata_big, VECS[v].exp_big);
         check($sformatf("vector %0d small", v), rdata_small, VECS[v].exp_small);
      end

      // R8: snapshot holds while the count moves on
      ticks(5);
      check("R8 hold", rdata_big, 32'd4396);
      bus_read(8'h08);
      check("R8 new snapshot", rdata_big, 32'd4401);
      check("R8 new snapshot small", rdata_small, 32'd49);

      // R9: write to the count offset is ignored
      bus_write(8'h08, 32'hFFFF_FFFF);
      bus_read(8'h08);
      check("R9 count write ignored", rdata_big, 32'd4401);
      // R9: only three control bits stored
      bus_write(8'h00, 32'h0000_FFFF);
      bus_read(8'h00);
      check("R9 ctrl readback", rdata_big, 32'h0000_4840);
      // R6: clear wins over freeze
      ticks(3);
      bus_read(8'h08);
      check("R6 clear over freeze", rdata_big, 32'd0);
      // R9: unmapped offset reads zero
      bus_read(8'h04);
      check("R9 unmapped", rdata_big, 32'd0);

      // R3: narrow wrap on the small instance, upper bits zero
      bus_write(8'h00, 32'h0);
      ticks(256);
      bus_read(8'h08);
      check("R3 narrow big", rdata_big, 32'd256);
      check("R3 narrow wrap small", rdata_small, 32'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end
endmodule